// File: doc/BRIEF.md
# Floating-Point Environment Save Sequencer

This block takes a snapshot of the floating-point unit's environment on a request and writes it to memory through a word-write port with valid/ready handshaking. The environment is made up of the control word, the status word, the tag word, the instruction pointer, the code selector with the last opcode, the data pointer and the data selector. The snapshot is taken in the cycle the request is accepted. Every earlier operation has completed by then, so the image shows the unit's state at that point.

A layout flag picks one of two images. The wide image is 28 bytes: seven 32-bit beats, with each 16-bit field zero-extended. The narrow image is 14 bytes: seven 16-bit beats. The waiting variant first tests for a pending unmasked exception. If it finds one, it raises an exception request and writes nothing. The no-wait variant skips this test. After the last beat is accepted, both variants write the control word back with every exception mask bit set, and they signal completion. The operation does not touch the condition flags and raises no floating-point exception of its own.

Top module: `fpu_env_save`

## Requirements
- R1: While reset is asserted and right after it, `mem_valid_o`, `done_o`, `ctrl_we_o`, `exc_req_o` and `busy_o` are all low.
- R2: With `wait_i`=1, a request is refused when a status bit i (i in 0..5) is 1 and control bit i is 0. In that case `exc_req_o` is high for exactly the one cycle after the request edge, no beat is issued and the control word is not written. Status bits above 5 and masked bits never refuse a request.
- R3: With `wait_i`=0, a pending unmasked exception does not stop the save. All seven beats are written and `exc_req_o` stays low.
- R4: With `wide_i`=1, the beats carry, in order: {16'h0,control}, {16'h0,status}, {16'h0,tag}, instruction pointer, {5'h0,opcode[10:0],code selector}, data pointer, {16'h0,data selector}. They go to base+0, 4, 8 … 24, and `mem_wide_o`=1.
- R5: With `wide_i`=0, the beats carry the low 16 bits of the same seven fields, in the same order, on `mem_data_o[15:0]`, with the upper half zero. They go to base+0, 2, 4 … 12, and `mem_wide_o`=0.
- R6: Every field, the base, and the layout are captured at the request edge. Input changes after that edge do not affect the beats or the control write-back.
- R7: A beat that is offered but not accepted (`mem_ready_i`=0) keeps its address and data unchanged in the next cycle.
- R8: In the cycle after the last beat is accepted, `done_o` and `ctrl_we_o` are high for one cycle, and `ctrl_wdata_o` equals the captured control word with bits 5..0 set.
- R9: A request that arrives while `busy_o` is high is ignored.
- R10: The first beat is offered in the cycle right after the request edge, and `busy_o` stays high from then until the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Save request |
| wait_i | input | 1 | 1: waiting variant, 0: no-wait variant |
| wide_i | input | 1 | 1: 28-byte image, 0: 14-byte image |
| base_i | input | AW | Image base address |
| ctrl_i | input | 16 | Control word |
| stat_i | input | 16 | Status word |
| tag_i | input | 16 | Tag word |
| ip_i | input | 32 | Instruction pointer |
| cs_i | input | 16 | Code selector |
| opc_i | input | 11 | Last opcode |
| dp_i | input | 32 | Data pointer |
| ds_i | input | 16 | Data selector |
| mem_valid_o | output | 1 | Write beat valid |
| mem_ready_i | input | 1 | Write beat accepted |
| mem_addr_o | output | AW | Byte address of the beat |
| mem_wide_o | output | 1 | Beat size: 1 = 32-bit, 0 = 16-bit |
| mem_data_o | output | 32 | Beat data |
| ctrl_we_o | output | 1 | Control word write-back strobe |
| ctrl_wdata_o | output | 16 | Control word with all masks set |
| done_o | output | 1 | Save complete pulse |
| exc_req_o | output | 1 | Exception request from the waiting variant |
| busy_o | output | 1 | Save in progress |

## Verification
After a request edge, the first beat is due in the following cycle and the exception request in that same cycle. Each accepted beat moves the address and data on at the next edge. The done pulse and the control write-back come one cycle after the edge that accepts the seventh beat. The bench's reference model steps once per rising edge with the same inputs the design sees, and every output is compared with it at the falling edge, so each result is checked in exactly the cycle it is due. Ready is held high in some runs and follows a pseudo-random pattern in others, which moves the done cycle while the one-cycle spacing stays fixed.

// File: rtl/fpu_env_pkg.sv
package fpu_env_pkg;
  localparam int NUM_BEATS = 7;
  localparam int BEAT_W    = 32;
  localparam int HALF_W    = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_FIN  = 2'd2
  } st_e;

  typedef struct packed {
    logic [15:0] ctrl;
    logic [15:0] stat;
    logic [15:0] tag;
    logic [31:0] ip;
    logic [15:0] cs;
    logic [10:0] opc;
    logic [31:0] dp;
    logic [15:0] ds;
    logic        wide;
  } env_t;
endpackage

// File: rtl/fpu_env_pending.sv
module fpu_env_pending #(
  parameter int MW = 6
) (
  input  logic [15:0] ctrl_i,
  input  logic [15:0] stat_i,
  output logic        pending_o
);
  logic [MW-1:0] hit;

  for (genvar g = 0; g < MW; g++) begin : g_bit
    assign hit[g] = stat_i[g] & ~ctrl_i[g];
  end

  assign pending_o = |hit;
endmodule

// File: rtl/fpu_env_addr_ctr.sv
module fpu_env_addr_ctr #(
  parameter int AW = 16,
  parameter int NB = 7,
  localparam int IW = $clog2(NB)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          step_i,
  input  logic          wide_i,
  output logic [IW-1:0] idx_o,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  logic [AW-1:0] base_q;
  logic [IW-1:0] idx_q;
  logic [AW-1:0] off;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      idx_q  <= '0;
    end else if (load_i) begin
      base_q <= base_i;
      idx_q  <= '0;
    end else if (step_i) begin
      idx_q <= idx_q + IW'(1);
    end
  end

  // byte offset: 4 per beat wide, 2 per beat narrow
  assign off    = wide_i ? (AW'(idx_q) << 2) : (AW'(idx_q) << 1);
  assign addr_o = base_q + off;
  assign idx_o  = idx_q;
  assign last_o = (idx_q == IW'(NB - 1));
endmodule

// File: rtl/fpu_env_beat_fmt.sv
module fpu_env_beat_fmt
  import fpu_env_pkg::*;
#(
  parameter int IW = 3
) (
  input  env_t              env_i,
  input  logic [IW-1:0]     idx_i,
  output logic [BEAT_W-1:0] data_o
);
  logic [BEAT_W-1:0] full;

  always_comb begin
    case (idx_i)
      IW'(0):  full = {16'h0, env_i.ctrl};
      IW'(1):  full = {16'h0, env_i.stat};
      IW'(2):  full = {16'h0, env_i.tag};
      IW'(3):  full = env_i.ip;
      IW'(4):  full = {5'h0, env_i.opc, env_i.cs};
      IW'(5):  full = env_i.dp;
      IW'(6):  full = {16'h0, env_i.ds};
      default: full = '0;
    endcase
  end

  // narrow layout keeps only the low half
  for (genvar g = 0; g < BEAT_W; g++) begin : g_lane
    if (g < HALF_W) begin : g_lo
      assign data_o[g] = full[g];
    end else begin : g_hi
      assign data_o[g] = full[g] & env_i.wide;
    end
  end
endmodule

// File: rtl/fpu_env_save.sv
module fpu_env_save
  import fpu_env_pkg::*;
#(
  parameter int AW = 16,
  parameter int MW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          wait_i,
  input  logic          wide_i,
  input  logic [AW-1:0] base_i,
  input  logic [15:0]   ctrl_i,
  input  logic [15:0]   stat_i,
  input  logic [15:0]   tag_i,
  input  logic [31:0]   ip_i,
  input  logic [15:0]   cs_i,
  input  logic [10:0]   opc_i,
  input  logic [31:0]   dp_i,
  input  logic [15:0]   ds_i,
  output logic          mem_valid_o,
  input  logic          mem_ready_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_wide_o,
  output logic [31:0]   mem_data_o,
  output logic          ctrl_we_o,
  output logic [15:0]   ctrl_wdata_o,
  output logic          done_o,
  output logic          exc_req_o,
  output logic          busy_o
);
  localparam int IW = $clog2(NUM_BEATS);
  localparam logic [15:0] MASK_ALL = 16'((1 << MW) - 1);

  st_e           st_q;
  env_t          snap_q, env_in;
  logic          exc_q;
  logic          pending, refuse, load, step, last;
  logic [IW-1:0] idx;

  fpu_env_pending #(.MW(MW)) u_pend (
    .ctrl_i   (ctrl_i),
    .stat_i   (stat_i),
    .pending_o(pending)
  );

  always_comb begin
    env_in.ctrl = ctrl_i;
    env_in.stat = stat_i;
    env_in.tag  = tag_i;
    env_in.ip   = ip_i;
    env_in.cs   = cs_i;
    env_in.opc  = opc_i;
    env_in.dp   = dp_i;
    env_in.ds   = ds_i;
    env_in.wide = wide_i;
  end

  assign refuse = (st_q == ST_IDLE) && req_i && wait_i && pending;
  assign load   = (st_q == ST_IDLE) && req_i && !(wait_i && pending);
  assign step   = (st_q == ST_SEND) && mem_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      snap_q <= '0;
      exc_q  <= 1'b0;
    end else begin
      exc_q <= refuse;
      unique case (st_q)
        ST_IDLE: if (load) begin
          st_q   <= ST_SEND;
          snap_q <= env_in;
        end
        ST_SEND: if (step && last) st_q <= ST_FIN;
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  fpu_env_addr_ctr #(.AW(AW), .NB(NUM_BEATS)) u_addr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .base_i(base_i),
    .step_i(step),
    .wide_i(snap_q.wide),
    .idx_o (idx),
    .addr_o(mem_addr_o),
    .last_o(last)
  );

  fpu_env_beat_fmt #(.IW(IW)) u_fmt (
    .env_i (snap_q),
    .idx_i (idx),
    .data_o(mem_data_o)
  );

  assign mem_valid_o  = (st_q == ST_SEND);
  assign mem_wide_o   = snap_q.wide;
  assign done_o       = (st_q == ST_FIN);
  assign ctrl_we_o    = (st_q == ST_FIN);
  assign ctrl_wdata_o = snap_q.ctrl | MASK_ALL;
  assign exc_req_o    = exc_q;
  assign busy_o       = (st_q != ST_IDLE);
endmodule

// File: rtl/fpu_env_save_chk.sv
module fpu_env_save_chk #(
  parameter int AW = 16,
  parameter int MW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          wait_i,
  input logic [15:0]   ctrl_i,
  input logic [15:0]   stat_i,
  input logic          mem_valid_o,
  input logic          mem_ready_i,
  input logic [AW-1:0] mem_addr_o,
  input logic [31:0]   mem_data_o,
  input logic          ctrl_we_o,
  input logic [15:0]   ctrl_wdata_o,
  input logic          done_o,
  input logic          exc_req_o,
  input logic          busy_o
);
  logic unmasked;
  assign unmasked = |(stat_i[MW-1:0] & ~ctrl_i[MW-1:0]);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (!mem_valid_o && !done_o && !exc_req_o && !busy_o);
    end
  end

  p_refuse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i && wait_i && unmasked) |=> (exc_req_o && !mem_valid_o));

  p_exc_no_beat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o |-> (!mem_valid_o && !ctrl_we_o));

  p_hold_beat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=>
      (mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o)));

  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_masks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ctrl_we_o && (ctrl_wdata_o[MW-1:0] == {MW{1'b1}})));

  p_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i && !(wait_i && unmasked)) |=> (mem_valid_o && busy_o));
endmodule

bind fpu_env_save fpu_env_save_chk #(.AW(AW), .MW(MW)) u_chk (.*);

// File: tb/fpu_env_save_test.sv
module fpu_env_save_test;
  localparam int CLK_P = 10;
  localparam int WD_CYC = 20000;

  logic clk_i = 1'b0;
  logic rst_n = 1'b1;
  logic req = 0, wt = 0, wd = 0, ready = 1;
  logic [15:0] base = 16'h0100, ctrl = 16'h0, stat = 16'h0, tag = 16'h0, cs = 16'h0, ds = 16'h0;
  logic [31:0] ip = 32'h0, dp = 32'h0;
  logic [10:0] opc = 11'h0;

  logic        mem_valid_o, mem_wide_o, ctrl_we_o, done_o, exc_req_o, busy_o;
  logic [15:0] mem_addr_o, ctrl_wdata_o;
  logic [31:0] mem_data_o;

  always #(CLK_P/2) clk_i = ~clk_i;

  fpu_env_save uut (
    .clk_i(clk_i), .rst_ni(rst_n), .req_i(req), .wait_i(wt), .wide_i(wd),
    .base_i(base), .ctrl_i(ctrl), .stat_i(stat), .tag_i(tag), .ip_i(ip),
    .cs_i(cs), .opc_i(opc), .dp_i(dp), .ds_i(ds),
    .mem_valid_o(mem_valid_o), .mem_ready_i(ready), .mem_addr_o(mem_addr_o),
    .mem_wide_o(mem_wide_o), .mem_data_o(mem_data_o), .ctrl_we_o(ctrl_we_o),
    .ctrl_wdata_o(ctrl_wdata_o), .done_o(done_o), .exc_req_o(exc_req_o),
    .busy_o(busy_o)
  );

  int n_cmp = 0, n_bad = 0, n_acc = 0;
  bit finished = 0, rdy_rand = 0;
  string cur_tag = "R1";
  logic [15:0] lfsr = 16'hACE1;

  // reference model
  int          m_phase = 0;
  logic        m_exc = 0, m_wide = 0;
  logic [15:0] m_ctrl = 0;
  logic [47:0] q[$];

  function automatic logic [31:0] field(int i);
    case (i)
      0: return {16'h0, ctrl};
      1: return {16'h0, stat};
      2: return {16'h0, tag};
      3: return ip;
      4: return {5'h0, opc, cs};
      5: return dp;
      default: return {16'h0, ds};
    endcase
  endfunction

  always @(posedge clk_i) begin
    if (!rst_n) begin
      m_phase = 0; m_exc = 0; q.delete();
    end else begin
      m_exc = 0;
      case (m_phase)
        0: if (req) begin
          if (wt && (|(stat[5:0] & ~ctrl[5:0]))) m_exc = 1;
          else begin
            m_wide = wd; m_ctrl = ctrl;
            for (int i = 0; i < 7; i++) begin
              logic [31:0] d;
              logic [15:0] a;
              d = field(i);
              if (!wd) d[31:16] = 16'h0;
              a = 16'(base + i * (wd ? 4 : 2));
              q.push_back({a, d});
            end
            m_phase = 1;
          end
        end
        1: if (ready) begin
          void'(q.pop_front());
          n_acc++;
          if (q.size() == 0) m_phase = 2;
        end
        default: m_phase = 0;
      endcase
    end
  end

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: got=%0h exp=%0h", tag, $time, got, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_n && !finished) begin
      chk("R10 valid", 64'(mem_valid_o), 64'(m_phase == 1));
      if (m_phase == 1 && q.size() > 0) begin
        chk({cur_tag, " addr"}, 64'(mem_addr_o), 64'(q[0][47:32]));
        chk({cur_tag, " data"}, 64'(mem_data_o), 64'(q[0][31:0]));
        chk({cur_tag, " wide"}, 64'(mem_wide_o), 64'(m_wide));
      end
      chk("R8 done", 64'(done_o), 64'(m_phase == 2));
      chk("R8 ctrl_we", 64'(ctrl_we_o), 64'(m_phase == 2));
      if (m_phase == 2) chk("R8 ctrl_wdata", 64'(ctrl_wdata_o), 64'(m_ctrl | 16'h003F));
      chk("R2 exc_req", 64'(exc_req_o), 64'(m_exc));
      chk("R9 busy", 64'(busy_o), 64'(m_phase != 0));
    end
  end

  task automatic tick();
    @(negedge clk_i);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ready = rdy_rand ? lfsr[0] : 1'b1;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 300 && (m_phase != 0 || busy_o); k++) tick();
    tick();
  endtask

  task automatic run_save(string tag, bit w, bit wdt, bit rnd, int exp_beats);
    int a0;
    cur_tag = tag; rdy_rand = rnd; a0 = n_acc;
    req = 1; wt = w; wd = wdt;
    tick();
    req = 0;
    wait_idle();
    chk({tag, " beat count"}, 64'(n_acc - a0), 64'(exp_beats));
  endtask

  task automatic load_fields(logic [15:0] c, logic [15:0] s, int seed);
    ctrl = c; stat = s;
    tag  = 16'(16'h5A00 + seed);
    ip   = 32'hC0DE_0000 + 32'(seed * 17);
    cs   = 16'(16'h0800 + seed);
    opc  = 11'(11'h5D3 ^ seed);
    dp   = 32'hDA7A_0000 + 32'(seed * 29);
    ds   = 16'(16'h0023 + seed);
    base = 16'(16'h0200 + seed * 64);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog: got=hung exp=finished");
      report();
    end
  end

  initial begin
    #1 rst_n = 0;
    repeat (3) @(negedge clk_i);
    // R1: outputs quiet in reset
    chk("R1 reset", 64'({mem_valid_o, done_o, ctrl_we_o, exc_req_o, busy_o}), 64'(0));
    rst_n = 1;
    tick();
    chk("R1 after reset", 64'({mem_valid_o, done_o, ctrl_we_o, exc_req_o, busy_o}), 64'(0));

    // R4: wide layout, ready always high
    load_fields(16'h0340, 16'h0000, 1);
    run_save("R4", 0, 1, 0, 7);

    // R5: narrow layout
    load_fields(16'h1200, 16'h0000, 2);
    run_save("R5", 0, 0, 0, 7);

    // R7: backpressure, both layouts
    load_fields(16'h0001, 16'h0000, 3);
    run_save("R7 wide", 0, 1, 1, 7);
    load_fields(16'h0010, 16'h0000, 4);
    run_save("R7 narrow", 0, 0, 1, 7);

    // R2: waiting variant refuses on unmasked pending bit 2
    load_fields(16'h0000, 16'h0004, 5);
    run_save("R2 refuse", 1, 1, 0, 0);
    // R2: same bit masked -> proceeds
    load_fields(16'h0004, 16'h0004, 6);
    run_save("R2 masked", 1, 1, 0, 7);
    // R2: status bit above the mask field never refuses
    load_fields(16'h0000, 16'h0040, 7);
    run_save("R2 high bit", 1, 0, 0, 7);

    // R3: no-wait variant ignores pending exception
    load_fields(16'h0000, 16'h0021, 8);
    run_save("R3", 0, 1, 1, 7);

    // R6: inputs change after the request edge
    load_fields(16'h0100, 16'h0000, 9);
    cur_tag = "R6"; rdy_rand = 1;
    req = 1; wt = 0; wd = 1;
    tick();
    req = 0;
    load_fields(16'hFFC0, 16'h003F, 10);
    wd = 0;
    tick();
    ip = 32'hFFFF_FFFF; ctrl = 16'h0;
    wait_idle();

    // R9: request during a save is ignored
    load_fields(16'h0000, 16'h0000, 11);
    cur_tag = "R9"; rdy_rand = 0;
    req = 1; wt = 0; wd = 1;
    tick();
    req = 0;
    tick();
    base = 16'h7000; req = 1; wd = 0;
    tick();
    req = 0;
    wait_idle();

    // R8/R10: request held high across back-to-back saves
    load_fields(16'h0000, 16'h0000, 12);
    cur_tag = "R8 back-to-back"; rdy_rand = 1;
    req = 1; wt = 1; wd = 1;
    for (int k = 0; k < 40; k++) tick();
    req = 0;
    wait_idle();

    finished = 1;
    report();
  end
endmodule